// File: doc/BRIEF.md
# Link-side transmit phase sequencer

This block is the link-layer half of a PHY-Link interface on a serial bus, for the transmit direction only. Once the PHY has won arbitration and signals Grant on the shared 2-bit control lines, the sequencer takes over both the control lines and the 8-bit data lines. It runs them through the fixed phases the PHY expects: one Idle cycle, an optional Hold while the packet source is not ready, then Transmit with one packet byte per cycle. After the packet it plays a two-cycle tail and then stops driving.

Packet bytes come from an internal valid/ready byte stream with an end-of-packet flag. With the last byte the source can ask to keep the bus for another packet. In that case the first tail cycle drives Hold with a transfer-rate code on the data lines instead of Idle. If the source never supplies data, Hold ends after a bounded number of cycles, a timeout pulse is raised and the bus is handed back. The shared lines are modelled as value outputs plus one registered drive enable. The source is expected to keep `tx_valid_i` high from the first byte to the last; a gap inside a packet is treated as an end of packet with no concatenation.

Top module: `link_tx_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `drive_en_o`, `tx_ready_o` and `hold_timeout_o` are 0 and `ctl_o` and `d_o` are all zero.
- R2: When the PHY drives Grant (`phy_ctl_i` = 2'b11) in a cycle where `drive_en_o` is 0, the next cycle has `drive_en_o` = 1 with Idle (`ctl_o` = 2'b00) and `d_o` = 0. Any `phy_ctl_i` value in a cycle where `drive_en_o` is 1 has no effect on the outputs.
- R3: Exactly one Idle cycle follows the grant before Hold or Transmit; the cycle after it is never Idle.
- R4: If a byte is offered during that Idle cycle, Transmit follows at once with no Hold cycle.
- R5: While no byte is offered, the sequencer drives Hold (`ctl_o` = 2'b01, `d_o` = 0) for at most MAX_HOLD consecutive cycles.
- R6: A byte is taken when `tx_valid_i` and `tx_ready_o` are both 1 at a clock edge. Each taken byte appears on `d_o` with Transmit (`ctl_o` = 2'b10) in the next cycle, in order, and the first byte appears in the very cycle Transmit first appears.
- R7: After the cycle with the last byte, one tail cycle follows. Without concatenation it is Idle with `d_o` = 0. With `chain_req_i` = 1 sampled with the last byte, it is Hold with `chain_speed_i` (as sampled with the last byte) zero-extended on `d_o`. Next comes one Idle cycle with `d_o` = 0, and then `drive_en_o` falls to 0.
- R8: If MAX_HOLD Hold cycles pass with no byte offered, `hold_timeout_o` is 1 for exactly one cycle. That cycle is Idle with `d_o` = 0, one more driven all-zero cycle follows, and then `drive_en_o` is 0. No byte is taken in this sequence.
- R9: While driving, `ctl_o` is never 2'b11, and `d_o` is zero in every Idle cycle. The last driven cycle before `drive_en_o` falls has `ctl_o` and `d_o` zero.
- R10: `tx_ready_o` is 1 only in the lead Idle cycle, in Hold cycles before the timeout, and in Transmit cycles before the last byte has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phy_ctl_i | input | 2 | Control value driven by the PHY; 2'b11 is Grant |
| tx_valid_i | input | 1 | Packet byte offered |
| tx_data_i | input | DATA_W | Packet byte |
| tx_last_i | input | 1 | Offered byte is the last of its packet |
| tx_ready_o | output | 1 | Sequencer takes the offered byte at this edge |
| chain_req_i | input | 1 | Keep the bus for another packet; sampled with the last byte |
| chain_speed_i | input | SPD_W | Transfer-rate code of the next packet; sampled with the last byte |
| ctl_o | output | 2 | Control value driven by the link |
| d_o | output | DATA_W | Data value driven by the link |
| drive_en_o | output | 1 | Link drives control and data lines (registered) |
| hold_timeout_o | output | 1 | One-cycle pulse when Hold expired without data |

## Verification
The grant response is tried with the first byte already waiting during the lead Idle, which shows the direct path to Transmit. It is also tried with data arriving after a random delay, which shows how long Hold lasts. A delay of exactly MAX_HOLD and one of MAX_HOLD plus one separate the last permitted Hold cycle from the timeout sequence. Packets of one byte and of several bytes, each with and without a concatenation request, show the tail variants and that the rate code is taken only with the last byte. Random PHY control values, Grant included, are applied while the link is driving to show they are ignored.

// File: rtl/link_tx_pkg.sv
package link_tx_pkg;

    localparam logic [1:0] CTL_IDLE  = 2'b00;
    localparam logic [1:0] CTL_HOLD  = 2'b01;
    localparam logic [1:0] CTL_XMIT  = 2'b10;
    localparam logic [1:0] CTL_GRANT = 2'b11;

    typedef enum logic [2:0] {
        PH_OFF,
        PH_LEAD,
        PH_HOLD,
        PH_XMIT,
        PH_TAIL1,
        PH_TAIL2,
        PH_TO_IDLE,
        PH_TO_LOW
    } phase_e;

endpackage

// File: rtl/tx_hold_timer.sv
module tx_hold_timer #(
    parameter int MAX_HOLD = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_next_i,
    output logic expired_o
);
    localparam int CNT_W = $clog2(MAX_HOLD + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_HOLD);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (hold_next_i) begin
            cnt_d = (cnt_q == LIMIT) ? cnt_q : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/tx_line_encoder.sv
module tx_line_encoder
    import link_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SPD_W  = 2
) (
    input  phase_e            phase_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              chain_i,
    input  logic [SPD_W-1:0]  speed_i,
    output logic [1:0]        ctl_o,
    output logic [DATA_W-1:0] d_o,
    output logic              en_o
);
    localparam int PAD_W = DATA_W - SPD_W;

    always_comb begin
        ctl_o = CTL_IDLE;
        d_o   = '0;
        en_o  = 1'b1;
        unique case (phase_i)
            PH_OFF:   en_o = 1'b0;
            PH_HOLD:  ctl_o = CTL_HOLD;
            PH_XMIT: begin
                ctl_o = CTL_XMIT;
                d_o   = byte_i;
            end
            PH_TAIL1: begin
                if (chain_i) begin
                    ctl_o = CTL_HOLD;
                    d_o   = {{PAD_W{1'b0}}, speed_i};
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/link_tx_sequencer.sv
module link_tx_sequencer
    import link_tx_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SPD_W    = 2,
    parameter int MAX_HOLD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        phy_ctl_i,
    input  logic              tx_valid_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_last_i,
    output logic              tx_ready_o,
    input  logic              chain_req_i,
    input  logic [SPD_W-1:0]  chain_speed_i,
    output logic [1:0]        ctl_o,
    output logic [DATA_W-1:0] d_o,
    output logic              drive_en_o,
    output logic              hold_timeout_o
);
    typedef struct packed {
        phase_e            phase;
        logic              last;
        logic              chain;
        logic [SPD_W-1:0]  speed;
        logic [DATA_W-1:0] data;
    } seq_t;

    typedef struct packed {
        logic              en;
        logic [1:0]        ctl;
        logic [DATA_W-1:0] d;
        logic              to;
    } line_t;

    seq_t  st_d, st_q;
    line_t line_d, line_q;

    logic              take;
    logic              expired;
    logic [1:0]        enc_ctl;
    logic [DATA_W-1:0] enc_d;
    logic              enc_en;

    tx_hold_timer #(.MAX_HOLD(MAX_HOLD)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_next_i (st_d.phase == PH_HOLD),
        .expired_o   (expired)
    );

    tx_line_encoder #(.DATA_W(DATA_W), .SPD_W(SPD_W)) u_enc (
        .phase_i (st_d.phase),
        .byte_i  (st_d.data),
        .chain_i (st_d.chain),
        .speed_i (st_d.speed),
        .ctl_o   (enc_ctl),
        .d_o     (enc_d),
        .en_o    (enc_en)
    );

    always_comb begin
        tx_ready_o = (st_q.phase == PH_LEAD) || (st_q.phase == PH_HOLD) ||
                     ((st_q.phase == PH_XMIT) && !st_q.last);
        take = tx_valid_i && tx_ready_o;
        st_d = st_q;

        unique case (st_q.phase)
            PH_OFF: begin
                if (phy_ctl_i == CTL_GRANT) st_d.phase = PH_LEAD;
            end
            PH_LEAD: begin
                st_d.phase = take ? PH_XMIT : PH_HOLD;
            end
            PH_HOLD: begin
                if (take)         st_d.phase = PH_XMIT;
                else if (expired) st_d.phase = PH_TO_IDLE;
            end
            PH_XMIT: begin
                if (!take) begin
                    st_d.phase = PH_TAIL1;
                    if (!st_q.last) st_d.chain = 1'b0;
                end
            end
            PH_TAIL1:   st_d.phase = PH_TAIL2;
            PH_TAIL2:   st_d.phase = PH_OFF;
            PH_TO_IDLE: st_d.phase = PH_TO_LOW;
            PH_TO_LOW:  st_d.phase = PH_OFF;
            default:    st_d.phase = PH_OFF;
        endcase

        if (take) begin
            st_d.data = tx_data_i;
            st_d.last = tx_last_i;
            if (tx_last_i) begin
                st_d.chain = chain_req_i;
                st_d.speed = chain_speed_i;
            end
        end
        if (st_d.phase == PH_OFF) begin
            st_d.last = 1'b0;
        end

        line_d.en  = enc_en;
        line_d.ctl = enc_ctl;
        line_d.d   = enc_d;
        line_d.to  = (st_d.phase == PH_TO_IDLE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_OFF;
            line_q     <= '0;
        end else begin
            st_q   <= st_d;
            line_q <= line_d;
        end
    end

    assign ctl_o          = line_q.ctl;
    assign d_o            = line_q.d;
    assign drive_en_o     = line_q.en;
    assign hold_timeout_o = line_q.to;
endmodule

// File: rtl/link_tx_sequencer_checker.sv
module link_tx_sequencer_checker #(
    parameter int DATA_W   = 8,
    parameter int MAX_HOLD = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        phy_ctl_i,
    input logic [1:0]        ctl_o,
    input logic [DATA_W-1:0] d_o,
    input logic              drive_en_o,
    input logic              tx_ready_o,
    input logic              hold_timeout_o
);
    localparam int RUN_W = $clog2(MAX_HOLD + 2);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MAX_HOLD);

    logic [RUN_W-1:0] hold_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                                 hold_run_q <= '0;
        else if (drive_en_o && ctl_o == 2'b01)      hold_run_q <= (hold_run_q > RUN_MAX) ? hold_run_q : hold_run_q + 1'b1;
        else                                        hold_run_q <= '0;
    end

    p_lead_after_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!drive_en_o && phy_ctl_i == 2'b11) |=> (drive_en_o && ctl_o == 2'b00 && d_o == '0));

    p_single_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_en_o) |=> (drive_en_o && ctl_o != 2'b00));

    p_hold_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o && ctl_o == 2'b01) |-> (hold_run_q < RUN_MAX));

    p_timeout_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_timeout_o |-> (drive_en_o && ctl_o == 2'b00 && d_o == '0));

    p_timeout_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_timeout_o |=> (!hold_timeout_o && drive_en_o && ctl_o == 2'b00));

    p_no_grant_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en_o |-> (ctl_o != 2'b11));

    p_idle_data_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_en_o && ctl_o == 2'b00) |-> (d_o == '0));

    p_release_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_en_o) |-> ($past(ctl_o) == 2'b00 && $past(d_o) == '0));

    p_ready_driving_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> drive_en_o);
endmodule

bind link_tx_sequencer link_tx_sequencer_checker #(
    .DATA_W   (DATA_W),
    .MAX_HOLD (MAX_HOLD)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .phy_ctl_i      (phy_ctl_i),
    .ctl_o          (ctl_o),
    .d_o            (d_o),
    .drive_en_o     (drive_en_o),
    .tx_ready_o     (tx_ready_o),
    .hold_timeout_o (hold_timeout_o)
);

// File: tb/link_tx_sequencer_test.sv
`timescale 1ns/1ps
module link_tx_sequencer_test;
    localparam int DW   = 8;
    localparam int SW   = 2;
    localparam int MAXH = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    phy_ctl_i = 2'b00;
    logic          tx_valid_i = 1'b0;
    logic [DW-1:0] tx_data_i = '0;
    logic          tx_last_i = 1'b0;
    logic          tx_ready_o;
    logic          chain_req_i = 1'b0;
    logic [SW-1:0] chain_speed_i = '0;
    logic [1:0]    ctl_o;
    logic [DW-1:0] d_o;
    logic          drive_en_o;
    logic          hold_timeout_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int            g_d, g_n;
    bit            g_chain, g_to;
    logic [SW-1:0] g_spd;
    logic [DW-1:0] pkt [0:15];

    always #2 clk = ~clk;

    link_tx_sequencer #(.DATA_W(DW), .SPD_W(SW), .MAX_HOLD(MAXH)) uut (
        .clk, .rst_n, .phy_ctl_i, .tx_valid_i, .tx_data_i, .tx_last_i, .tx_ready_o,
        .chain_req_i, .chain_speed_i, .ctl_o, .d_o, .drive_en_o, .hold_timeout_o
    );

    // expected {en, ctl, d, timeout} in scenario cycle k (k = 0 is the grant cycle)
    function automatic logic [11:0] exp_line(int k);
        int t = 1 + g_d;
        if (k <= 0) return 12'h0;
        if (k == 1) return {1'b1, 2'b00, 8'h00, 1'b0};
        if (g_to) begin
            if (k <= 1 + MAXH) return {1'b1, 2'b01, 8'h00, 1'b0};
            if (k == 2 + MAXH) return {1'b1, 2'b00, 8'h00, 1'b1};
            if (k == 3 + MAXH) return {1'b1, 2'b00, 8'h00, 1'b0};
            return 12'h0;
        end
        if (k <= t)       return {1'b1, 2'b01, 8'h00, 1'b0};
        if (k <= t + g_n) return {1'b1, 2'b10, pkt[k-t-1], 1'b0};
        if (k == t + g_n + 1)
            return g_chain ? {1'b1, 2'b01, 6'h00, g_spd, 1'b0} : {1'b1, 2'b00, 8'h00, 1'b0};
        if (k == t + g_n + 2) return {1'b1, 2'b00, 8'h00, 1'b0};
        return 12'h0;
    endfunction

    function automatic bit exp_ready(int k);
        if (g_to) return (k >= 1 && k <= 1 + MAXH);
        return (k >= 1 && k <= g_d + g_n);
    endfunction

    function automatic string req_of(int k);
        int t = 1 + g_d;
        if (k <= 1) return "R2";
        if (g_to) return (k <= 1 + MAXH) ? "R5" : "R8";
        if (k == 2) return (g_d == 0) ? "R4" : "R3";
        if (k <= t) return "R5";
        if (k <= t + g_n) return "R6";
        return "R7";
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic run_case(int dl, int n, bit ch, logic [SW-1:0] sp);
        int bi = 0;
        int k_end;
        g_d = dl; g_n = n; g_chain = ch; g_spd = sp;
        g_to = (dl > MAXH);
        for (int i = 0; i < 16; i++) pkt[i] = DW'($urandom);
        k_end = g_to ? 4 + MAXH : 1 + dl + n + 3;
        for (int k = 0; k <= k_end; k++) begin
            @(negedge clk);
            chk(req_of(k), {20'h0, drive_en_o, ctl_o, d_o, hold_timeout_o}, {20'h0, exp_line(k)});
            chk("R10", {31'h0, tx_ready_o}, {31'h0, exp_ready(k)});
            if (drive_en_o) chk("R9", {31'h0, ctl_o == 2'b11}, 32'h0);
            // PHY side: grant in cycle 0, noise while the link drives (R2 ignore)
            if (k == 0)                  phy_ctl_i = 2'b11;
            else if (k >= 2 && k < k_end) phy_ctl_i = 2'($urandom);
            else                         phy_ctl_i = 2'b00;
            tx_valid_i = !g_to && (k >= 1 + dl) && (bi < n);
            tx_data_i  = pkt[bi < 16 ? bi : 0];
            tx_last_i  = (bi == n - 1);
            if (tx_valid_i && tx_last_i) begin
                chain_req_i   = ch;
                chain_speed_i = sp;
            end else begin
                chain_req_i   = 1'($urandom);
                chain_speed_i = SW'($urandom);
            end
            if (tx_valid_i && exp_ready(k)) bi++;
        end
        tx_valid_i = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held
        chk("R1", {28'h0, drive_en_o, tx_ready_o, hold_timeout_o, |{ctl_o, d_o}}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {28'h0, drive_en_o, tx_ready_o, hold_timeout_o, |{ctl_o, d_o}}, 32'h0);

        run_case(0, 1, 1'b0, 2'd0);        // R4: direct transmit, single byte
        run_case(0, 4, 1'b1, 2'd2);        // R7: concatenation tail
        run_case(MAXH, 3, 1'b0, 2'd1);     // R5: last permitted hold cycle
        run_case(MAXH + 1, 2, 1'b1, 2'd3); // R8: hold expiry
        run_case(1, 1, 1'b1, 2'd3);        // R6: one hold then single byte
        run_case(MAXH + 2, 1, 1'b0, 2'd0); // R8 again back to back
        for (int r = 0; r < 40; r++) begin
            run_case(int'($urandom % (MAXH + 3)), 1 + int'($urandom % 8),
                     1'($urandom), SW'($urandom));
        end
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule